// File: doc/BRIEF.md
# Iterative Radix-4 Integer Multiplier with Early Exit

This block is the multiply engine of an integer execution unit. It accepts two 64-bit operands and a 2-bit mode. From the product it returns the low 64 bits. The mode selects one of three operand formats:

- 32-bit unsigned, where the low halves are zero-extended.
- 32-bit signed, where the low halves are sign-extended.
- Full 64-bit.

The first operand `in_a` is the multiplier. The engine scans it two bits per clock with radix-4 Booth recoding, and the overlap bit comes from the previous step. The second operand `in_b` is the multiplicand. It is shifted left two places per step.

The engine stops as soon as the multiplier bits still unscanned, together with the overlap bit, are all equal. At that point every remaining Booth digit is zero. Latency therefore follows the significant width of the first operand, so callers should place the smaller-magnitude value in `in_a`.

Operands enter on a valid/ready pair. A request is taken on a rising clock edge where both `in_valid` and `in_ready` are high. While a multiply runs, `in_ready` is low and any request on `in_valid` waits: it has no effect.

Results leave as a single-cycle `out_valid` pulse with `out_data`. There is no back-pressure on the result side, so the consumer must capture the product in the pulse cycle. `in_ready` is already high in that cycle, so a waiting request is taken at the same edge and multiplies run back to back.

Top module: `imul_radix4`

## Requirements
- R1: `in_mode` encoding sets how operands are formed. In mode 2'b00 the low 32 bits of both operands are zero-extended. In mode 2'b01 the low 32 bits of both operands are sign-extended. In modes 2'b10 and 2'b11 all 64 bits are used. `out_data` is the low 64 bits of the product of the formed operands, and the upper halves of the inputs have no effect in the 32-bit modes.
- R2: Define the accept edge as edge 0. Let k be the least integer of at least 1 such that the formed first operand fits in a 2k-bit two's-complement value. Then `out_valid` is high for the cycle that follows edge k.
- R3: k never exceeds 32 in 64-bit mode, 16 in signed 32-bit mode, or 17 in unsigned 32-bit mode.
- R4: A first operand of zero, or of all ones after forming, finishes with k = 1.
- R5: `out_valid` is a one-cycle pulse, and `out_data` holds the product in that cycle.
- R6: `in_ready` falls at the accept edge and stays low until the cycle of the matching `out_valid`. In that cycle `in_ready` is high.
- R7: `in_valid` asserted while `in_ready` is low has no effect on the running product or its timing.
- R8: A request presented in an `out_valid` cycle is accepted at the next edge, and that edge counts as edge 0 for the new operation.
- R9: During and immediately after reset, `in_ready` is 1 and `out_valid` is 0.
- R10: The multiplicand value never changes the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand request |
| in_ready | output | 1 | Engine idle, request taken on this edge |
| in_mode | input | 2 | 00 unsigned 32, 01 signed 32, 1x full 64 |
| in_a | input | 64 | Multiplier, scanned operand |
| in_b | input | 64 | Multiplicand |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 64 | Low 64 bits of the product |

## Verification
Delivering a result and accepting the next request can happen in the same cycle, because `in_ready` returns high in the `out_valid` cycle. The bench provokes this overlap by keeping `in_valid` high with the next operands throughout a running multiply. It then checks that the finishing product matches its reference. It also checks that the waiting request's latency is counted from that very edge. The same stream also shows that requests held during busy cycles disturb neither result.

// File: rtl/imul_pkg.sv
package imul_pkg;
  localparam logic [1:0] MODE_U32 = 2'b00;
  localparam logic [1:0] MODE_S32 = 2'b01;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_t;

  function automatic booth_t booth_decode(input logic [2:0] tri_bits);
    booth_t d;
    d.neg = tri_bits[2] & ~(tri_bits[1] & tri_bits[0]);
    d.one = tri_bits[1] ^ tri_bits[0];
    d.two = (tri_bits == 3'b011) | (tri_bits == 3'b100);
    return d;
  endfunction
endpackage

// File: rtl/imul_opnd_ext.sv
module imul_opnd_ext #(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] formed
);
  import imul_pkg::*;
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    case (mode)
      MODE_U32: formed = {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
      MODE_S32: formed = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
      default:  formed = raw;
    endcase
  end
endmodule

// File: rtl/imul_booth_pp.sv
module imul_booth_pp #(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        tri_bits,
  input  logic [DATA_W-1:0] mcand,
  output logic [DATA_W-1:0] pp
);
  import imul_pkg::*;
  booth_t            dig;
  logic [DATA_W-1:0] mag;

  always_comb begin
    dig = booth_decode(tri_bits);
    if (dig.two)      mag = mcand << 1;
    else if (dig.one) mag = mcand;
    else              mag = '0;
    pp = dig.neg ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/imul_exit_det.sv
module imul_exit_det #(
  parameter int Q_W = 65
) (
  input  logic [Q_W-1:0] scan,
  output logic           uniform
);
  assign uniform = (&scan) | ~(|scan);
endmodule

// File: rtl/imul_radix4.sv
module imul_radix4 #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  localparam int Q_W    = DATA_W + 1;
  localparam int N_OPND = 2;

  logic              busy;
  logic [Q_W-1:0]    scan_q;
  logic [DATA_W-1:0] mcand_q;
  logic [DATA_W-1:0] acc_q;

  logic [DATA_W-1:0] raw_op    [N_OPND];
  logic [DATA_W-1:0] formed_op [N_OPND];

  assign raw_op[0] = in_a;
  assign raw_op[1] = in_b;

  for (genvar g = 0; g < N_OPND; g++) begin : g_ext
    imul_opnd_ext #(.DATA_W(DATA_W)) u_ext (
      .mode   (in_mode),
      .raw    (raw_op[g]),
      .formed (formed_op[g])
    );
  end

  logic [DATA_W-1:0] pp;
  logic [DATA_W-1:0] acc_next;
  logic [Q_W-1:0]    scan_next;
  logic [DATA_W-1:0] mcand_next;
  logic              done_now;
  logic              accept;

  imul_booth_pp #(.DATA_W(DATA_W)) u_pp (
    .tri_bits (scan_q[2:0]),
    .mcand    (mcand_q),
    .pp       (pp)
  );

  assign acc_next   = acc_q + pp;
  assign scan_next  = Q_W'($signed(scan_q) >>> 2);
  assign mcand_next = mcand_q << 2;

  imul_exit_det #(.Q_W(Q_W)) u_exit (
    .scan    (scan_next),
    .uniform (done_now)
  );

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      scan_q    <= '0;
      mcand_q   <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        scan_q  <= {formed_op[0], 1'b0};
        mcand_q <= formed_op[1];
        acc_q   <= '0;
      end else if (busy) begin
        acc_q   <= acc_next;
        scan_q  <= scan_next;
        mcand_q <= mcand_next;
        if (done_now) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= acc_next;
        end
      end
    end
  end
endmodule

// File: rtl/imul_radix4_chk.sv
module imul_radix4_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_mode,
  input logic [DATA_W-1:0] in_a,
  input logic              out_valid
);
  localparam int HALF_W = DATA_W / 2;
  localparam int ITER_W = $clog2(DATA_W / 2 + 2);
  localparam logic [ITER_W-1:0] LIM_W64 = ITER_W'(DATA_W / 2);
  localparam logic [ITER_W-1:0] LIM_S32 = ITER_W'(HALF_W / 2);
  localparam logic [ITER_W-1:0] LIM_U32 = ITER_W'(HALF_W / 2 + 1);

  logic [ITER_W-1:0] cnt;
  logic [ITER_W-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= LIM_W64;
    end else if (in_valid && in_ready) begin
      cnt <= '0;
      lim <= in_mode[1] ? LIM_W64 : (in_mode[0] ? LIM_S32 : LIM_U32);
    end else if (!in_ready) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_at_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  p_ready_only_with_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid);

  p_iter_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt >= 1 && cnt <= lim));

  p_zero_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a == '0) |-> ##2 out_valid);
endmodule

bind imul_radix4 imul_radix4_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_mode   (in_mode),
  .in_a      (in_a),
  .out_valid (out_valid)
);

// File: tb/test_imul_radix4.sv
module test_imul_radix4;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_mode = 2'b00;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;

  imul_radix4 #(.DATA_W(W)) i_imul_radix4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  typedef struct {
    logic [W-1:0] prod;
    int           due;
    int           iters;
    logic [1:0]   mode;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] form(input logic [1:0] m, input logic [W-1:0] v);
    if (m == 2'b00) return {32'h0, v[31:0]};
    if (m == 2'b01) return {{32{v[31]}}, v[31:0]};
    return v;
  endfunction

  function automatic int exp_iters(input logic [W-1:0] x);
    logic signed [W-1:0] s;
    for (int k = 1; k <= W / 2; k++) begin
      s = $signed(x) >>> (2 * k - 1);
      if (s == 0 || s == -1) return k;
    end
    return W / 2 + 1;
  endfunction

  // driver: called at a negedge, leaves in_valid high at the negedge after acceptance
  task automatic send(input logic [1:0] m, input logic [W-1:0] a, input logic [W-1:0] b);
    item_t it;
    logic [W-1:0] fa, fb;
    in_valid = 1'b1;
    in_mode  = m;
    in_a     = a;
    in_b     = b;
    while (!in_ready) @(negedge clk);
    fa = form(m, a);
    fb = form(m, b);
    it.prod  = fa * fb;
    it.iters = exp_iters(fa);
    it.due   = cyc + 1 + it.iters;
    it.mode  = m;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle_until_empty();
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R5 unexpected result", out_data, '0);
      end else begin
        item_t it;
        int lim;
        it = sb.pop_front();
        chk(out_data == it.prod, "R1 product", out_data, it.prod);
        chk(cyc == it.due, "R2 latency", W'(cyc), W'(it.due));
        lim = it.mode[1] ? 32 : (it.mode[0] ? 16 : 17);
        chk(it.iters <= lim, "R3 iteration bound", W'(it.iters), W'(lim));
        chk(in_ready == 1'b1, "R6 ready in result cycle", W'(in_ready), 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready in reset", W'(in_ready), 1);
    chk(out_valid == 1'b0, "R9 no result in reset", W'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", W'(in_ready), 1);
    chk(out_valid == 1'b0, "R9 idle after reset", W'(out_valid), 0);

    // R4: zero and all-ones multipliers
    send(2'b10, 64'h0, 64'h1234_5678_9abc_def0);
    chk(in_ready == 1'b0, "R6 busy after accept", W'(in_ready), 0);
    idle_until_empty();
    send(2'b01, 64'hdead_beef_ffff_ffff, 64'h0000_0000_0000_0007);
    idle_until_empty();
    send(2'b10, 64'hffff_ffff_ffff_ffff, 64'h8000_0000_0000_0001);
    idle_until_empty();

    // R3: worst cases per mode
    send(2'b00, 64'h5555_0000_ffff_ffff, 64'hffff_ffff_ffff_ffff);
    idle_until_empty();
    send(2'b01, 64'h0000_0000_8000_0000, 64'h0000_0000_7fff_ffff);
    idle_until_empty();
    send(2'b10, 64'h8000_0000_0000_0000, 64'h3);
    idle_until_empty();
    send(2'b11, 64'h7fff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffd);
    idle_until_empty();

    // R1: upper halves ignored in 32-bit modes; small values; R10 same a, different b
    send(2'b00, 64'hffff_ffff_0000_0003, 64'habcd_0000_0000_0005);
    idle_until_empty();
    send(2'b00, 64'h1111_2222_0000_0003, 64'h0000_0000_ffff_fffb);
    idle_until_empty();
    send(2'b01, 64'h0000_0000_ffff_fffd, 64'hffff_0000_0000_0009);
    idle_until_empty();

    // R7: requests held while busy must not disturb the running product
    send(2'b10, 64'h0000_0fff_ffff_ffff, 64'h0000_0000_0000_0011);
    in_mode = 2'b00;
    in_a = '0;
    in_b = 64'hffff;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    idle_until_empty();

    // R8: back-to-back stream, next request waiting during every busy phase
    for (int i = 0; i < 40; i++) begin
      r = {$urandom, $urandom} >> ($urandom % 64);
      send(2'($urandom % 4), r, {$urandom, $urandom});
    end
    idle_until_empty();

    for (int i = 0; i < 200; i++) begin
      r = {$urandom, $urandom};
      if (i % 3 == 0) r = -(r >> ($urandom % 64));
      send(2'($urandom % 4), r, {$urandom, $urandom});
      if (i % 7 == 0) idle_until_empty();
    end
    idle_until_empty();

    chk(sb.size() == 0, "R5 all results delivered", W'(sb.size()), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule